// File: doc/BRIEF.md
# Three-Wire Serial Display RAM and Command Interface

This block is the slave side of a three-wire host link for a segment display controller. The host drives a select line, a write strobe, a read strobe and a shared data line. The block samples all of them through synchronizers on a fast internal clock. A transfer starts with a 3-bit operation code. The code selects one of three things: writing 4-bit words into the display RAM, reading words out of it, or passing 9-bit control words to the rest of the controller.

In the two RAM operations, a 6-bit start address comes after the code. Each later 4-bit word uses the next address, and the address wraps from 63 to 0. The chosen operation stays in force for as long as select is held low, so the host can stream many words or many control words after a single code. Raising select discards any partial frame and clears the operation. The display RAM sits outside the block and is reached through a simple synchronous port. Decoded control words leave the block as a one-cycle strobe with the code beside it.

The shared data line is modelled as an input, an output and an output enable, so a pad cell or a tri-state driver can be placed around the block.

Top module: `lcd_serial_if`

## Requirements
- R1: After reset, `host_doe`, `ram_we`, `ram_re` and `cmd_valid` are all low.
- R2: With select low, the bits 1,0,1 sampled at rising edges of `host_wr` start a write. The next 6 bits form the address, MSB first. The next 4 bits are data, bit 0 first. Together they produce one `ram_we` pulse carrying that address and that data.
- R3: In write mode, each further group of 4 bits is written to the previous address plus one, modulo 64 (63 is followed by 0). No new code or address is needed.
- R4: The bits 1,1,0 followed by a 6-bit address (MSB first) start a read. From then on, each rising edge of `host_rd` places the next bit of the RAM word on `host_dout`, bit 0 first. After 4 bits, reading continues with the word at the next address modulo 64.
- R5: `host_doe` stays low until the first rising edge of `host_rd` in the read data phase. It stays high through the read data phase and goes low once select is high.
- R6: The bits 1,0,0 followed by 9 bits (C8 first) produce one single-cycle `cmd_valid` pulse, with `cmd_code[8:0]` equal to those 9 bits.
- R7: While select stays low after a 1,0,0 code, every further 9 bits produce another command. No code is repeated.
- R8: Select high discards a partial frame: no write and no command results from it. After select falls again, the first 3 bits are always read as an operation code.
- R9: An operation code other than 110, 101 or 100 causes every write-strobe bit to be ignored until select goes high: no RAM write and no command.
- R10: `ram_we` and `cmd_valid` are single-cycle pulses, and `ram_we` and `ram_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Host select, low enables transfers |
| host_wr | input | 1 | Host write strobe, data taken on rising edge |
| host_rd | input | 1 | Host read strobe, data driven on rising edge |
| host_din | input | 1 | Data line value seen from the pad |
| host_dout | output | 1 | Read bit driven towards the pad |
| host_doe | output | 1 | Output enable for the data line |
| ram_addr | output | 6 | Display RAM address |
| ram_we | output | 1 | Display RAM write enable |
| ram_re | output | 1 | Display RAM read enable, data returned next cycle |
| ram_wdata | output | 4 | Display RAM write data |
| ram_rdata | input | 4 | Display RAM read data |
| cmd_valid | output | 1 | One-cycle strobe for a decoded control word |
| cmd_code | output | 9 | Control word, C8 in the top bit |

## Verification
A corrupted bit counter or phase register shows up within a single frame. Writes land at shifted addresses, or the `ram_we` count differs from the number of words sent, or a command carries bits rotated by one position. A stale address pointer shows up at the first wrap from 63 to 0, which both the write sweep and the read sweep cross. A mode that survives a high select shows up in the very next window: there, a 9-bit command with no code in front must not yield a strobe.

// File: rtl/lcdif_pkg.sv
// Package: shared widths, operation codes and frame phases for the
// three-wire display interface. Assumes MSB-first codes.
package lcdif_pkg;
    localparam int ID_W   = 3;
    localparam int ADDR_W = 6;
    localparam int NIB_W  = 4;
    localparam int CMD_W  = 9;

    localparam logic [ID_W-1:0] OP_READ  = 3'b110;
    localparam logic [ID_W-1:0] OP_WRITE = 3'b101;
    localparam logic [ID_W-1:0] OP_CMD   = 3'b100;

    typedef enum logic [2:0] {
        PH_ID,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_CMD,
        PH_DROP
    } phase_e;
endpackage

// File: rtl/lcdif_sync.sv
// Module: multi-bit level synchronizer. Each input bit passes through
// STAGES flops. Assumes the inputs are asynchronous and slow compared
// with clk. Reset loads RST_VAL (idle levels of the pulled-up lines).
module lcdif_sync #(
    parameter int             N       = 4,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift one input bit through its flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], async_in[b]};
            end
            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lcdif_seq.sv
// Module: frame sequencer. Takes synchronized select/strobe/data levels,
// finds strobe rising edges, decodes the operation code, collects
// address/data/command bits, drives the RAM port and the read bit.
// Assumes each strobe level lasts several clk cycles.
module lcdif_seq
    import lcdif_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = NIB_W,
    parameter int C_W = CMD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_lvl,
    input  logic           wr_lvl,
    input  logic           rd_lvl,
    input  logic           din,
    input  logic [D_W-1:0] ram_rdata,
    output logic [A_W-1:0] ram_addr,
    output logic           ram_we,
    output logic           ram_re,
    output logic [D_W-1:0] ram_wdata,
    output logic           cmd_valid,
    output logic [C_W-1:0] cmd_code,
    output logic           dout,
    output logic           doe
);
    localparam int CNT_W = $clog2(C_W);
    localparam int NB_W  = $clog2(D_W);

    phase_e          phase;
    logic [CNT_W-1:0] bcnt;
    logic [C_W-2:0]  sh;
    logic [C_W-1:0]  sh_next;
    logic [A_W-1:0]  ptr;
    logic [D_W-1:0]  nib, nib_next, rnib;
    logic            mode_rd, rd_pend, wr_q, rd_q;
    logic            wr_rise, rd_rise;
    logic [NB_W-1:0] bidx;

    // Edge detection and the next shift-register / nibble values.
    always_comb begin
        wr_rise        = wr_lvl & ~wr_q;
        rd_rise        = rd_lvl & ~rd_q;
        sh_next        = {sh, din};
        bidx           = bcnt[NB_W-1:0];
        nib_next       = nib;
        nib_next[bidx] = din;
    end

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_lvl;
            rd_q <= rd_lvl;
        end
    end

    // Frame state machine, RAM port and read-bit driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_ID;
            bcnt      <= '0;
            sh        <= '0;
            ptr       <= '0;
            nib       <= '0;
            rnib      <= '0;
            mode_rd   <= 1'b0;
            rd_pend   <= 1'b0;
            ram_addr  <= '0;
            ram_we    <= 1'b0;
            ram_re    <= 1'b0;
            ram_wdata <= '0;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            dout      <= 1'b0;
            doe       <= 1'b0;
        end else begin
            ram_we    <= 1'b0;
            ram_re    <= 1'b0;
            cmd_valid <= 1'b0;
            rd_pend   <= ram_re;
            if (rd_pend) rnib <= ram_rdata;
            if (sel_lvl) begin
                phase <= PH_ID;
                bcnt  <= '0;
                doe   <= 1'b0;
            end else begin
                if (wr_rise) begin
                    case (phase)
                        PH_ID: begin
                            sh <= sh_next[C_W-2:0];
                            if (bcnt == CNT_W'(ID_W-1)) begin
                                bcnt <= '0;
                                case (sh_next[ID_W-1:0])
                                    OP_READ:  begin phase <= PH_ADDR; mode_rd <= 1'b1; end
                                    OP_WRITE: begin phase <= PH_ADDR; mode_rd <= 1'b0; end
                                    OP_CMD:   phase <= PH_CMD;
                                    default:  phase <= PH_DROP;
                                endcase
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                        PH_ADDR: begin
                            sh <= sh_next[C_W-2:0];
                            if (bcnt == CNT_W'(A_W-1)) begin
                                bcnt <= '0;
                                if (mode_rd) begin
                                    ram_addr <= sh_next[A_W-1:0];
                                    ram_re   <= 1'b1;
                                    ptr      <= sh_next[A_W-1:0] + 1'b1;
                                    phase    <= PH_RDATA;
                                end else begin
                                    ptr      <= sh_next[A_W-1:0];
                                    phase    <= PH_WDATA;
                                end
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                        PH_WDATA: begin
                            nib <= nib_next;
                            if (bcnt == CNT_W'(D_W-1)) begin
                                bcnt      <= '0;
                                ram_we    <= 1'b1;
                                ram_addr  <= ptr;
                                ram_wdata <= nib_next;
                                ptr       <= ptr + 1'b1;
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                        PH_CMD: begin
                            sh <= sh_next[C_W-2:0];
                            if (bcnt == CNT_W'(C_W-1)) begin
                                bcnt      <= '0;
                                cmd_valid <= 1'b1;
                                cmd_code  <= sh_next;
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (rd_rise && phase == PH_RDATA) begin
                    doe  <= 1'b1;
                    dout <= rnib[bidx];
                    if (bcnt == CNT_W'(D_W-1)) begin
                        bcnt     <= '0;
                        ram_addr <= ptr;
                        ram_re   <= 1'b1;
                        ptr      <= ptr + 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lcd_serial_if.sv
// Module: top of the three-wire display interface. Synchronizes the four
// host lines and hands them to the frame sequencer. Assumes an external
// synchronous RAM that returns read data one cycle after ram_re.
module lcd_serial_if
    import lcdif_pkg::*;
#(
    parameter int A_W  = ADDR_W,
    parameter int D_W  = NIB_W,
    parameter int C_W  = CMD_W,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel_n,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic           host_din,
    output logic           host_dout,
    output logic           host_doe,
    output logic [A_W-1:0] ram_addr,
    output logic           ram_we,
    output logic           ram_re,
    output logic [D_W-1:0] ram_wdata,
    input  logic [D_W-1:0] ram_rdata,
    output logic           cmd_valid,
    output logic [C_W-1:0] cmd_code
);
    logic [3:0] lines_s;
    logic       sel_lvl, wr_lvl, rd_lvl, din_lvl;

    lcdif_sync #(.N(4), .STAGES(SYNC), .RST_VAL(4'hF)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_sel_n, host_wr, host_rd, host_din}),
        .sync_out (lines_s)
    );

    assign {sel_lvl, wr_lvl, rd_lvl, din_lvl} = lines_s;

    lcdif_seq #(.A_W(A_W), .D_W(D_W), .C_W(C_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_lvl   (sel_lvl),
        .wr_lvl    (wr_lvl),
        .rd_lvl    (rd_lvl),
        .din       (din_lvl),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .dout      (host_dout),
        .doe       (host_doe)
    );
endmodule

// File: rtl/lcd_serial_if_chk.sv
// Checker: port-level properties of the three-wire display interface,
// bound to every lcd_serial_if instance.
module lcd_serial_if_chk #(
    parameter int A_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sel_lvl,
    input logic           ram_we,
    input logic           ram_re,
    input logic [A_W-1:0] ram_addr,
    input logic           cmd_valid,
    input logic           host_doe
);
    logic [A_W-1:0] last_wa;
    logic           have_wa;

    // Remember the last write address inside one select-low window.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_lvl) begin
            have_wa <= 1'b0;
            last_wa <= '0;
        end else if (ram_we) begin
            have_wa <= 1'b1;
            last_wa <= ram_addr;
        end
    end

    // R10
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R6
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R10
    no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R8
    sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl |=> (!host_doe && !ram_we && !cmd_valid));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && have_wa && !sel_lvl) |-> (ram_addr == A_W'(last_wa + 1'b1)));
endmodule

bind lcd_serial_if lcd_serial_if_chk #(.A_W(A_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_lvl   (sel_lvl),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .cmd_valid (cmd_valid),
    .host_doe  (host_doe)
);

// File: tb/lcd_serial_if_tb_top.sv
// Bench: drives host frames slowly, models the display RAM, and
// compares against arithmetically computed expectations.
module lcd_serial_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, wr = 1'b1, rd = 1'b1, din = 1'b1;
    logic       host_dout, host_doe, ram_we, ram_re, cmd_valid;
    logic [5:0] ram_addr;
    logic [3:0] ram_wdata, ram_rdata;
    logic [8:0] cmd_code;

    int total = 0;
    int bad = 0;
    int wcount = 0;
    int cmd_n = 0;
    logic [3:0] mem [64];
    logic [5:0] wlog [256];
    logic [8:0] clog [64];

    always #2.5 clk = ~clk;

    lcd_serial_if dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_wr(wr),
        .host_rd(rd), .host_din(din), .host_dout(host_dout),
        .host_doe(host_doe), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    // Display RAM model and logs of writes and commands.
    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            if (wcount < 256) wlog[wcount] = ram_addr;
            wcount++;
        end
        if (ram_re) ram_rdata <= mem[ram_addr];
        if (cmd_valid) begin
            if (cmd_n < 64) clog[cmd_n] = cmd_code;
            cmd_n++;
        end
    end

    function automatic logic [3:0] pat(input int a);
        return 4'((a * 5 + 3) % 16);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b; wr = 1'b0; half(); wr = 1'b1; half();
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_nib(input logic [3:0] d);
        for (int i = 0; i < 4; i++) send_bit(d[i]);
    endtask

    task automatic rd_nib(output logic [3:0] d, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rd = 1'b0; half(); rd = 1'b1; half();
            d[i] = host_dout;
            oe_all &= host_doe;
        end
    endtask

    task automatic sel_low();
        sel_n = 1'b0; half();
    endtask

    task automatic sel_high();
        din = 1'b1; sel_n = 1'b1; half(); half();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] d;
        logic       oe;
        int         w0, c0;
        for (int a = 0; a < 64; a++) mem[a] = 4'h0;
        ram_rdata = 4'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(host_doe == 1'b0, "R1 doe", host_doe, 0);
        check(ram_we == 1'b0, "R1 we", ram_we, 0);
        check(cmd_valid == 1'b0, "R1 cmd", cmd_valid, 0);
        check(ram_re == 1'b0, "R1 re", ram_re, 0);

        // R2 R3: burst of 64 words from address 61, wrapping through 0
        sel_low();
        send_bits(16'b101, 3);
        send_bits(16'd61, 6);
        for (int k = 0; k < 64; k++) send_nib(pat((61 + k) % 64));
        sel_high();
        check(wcount == 64, "R2 write count", wcount, 64);
        check(wlog[0] == 6'd61, "R2 first address", wlog[0], 61);
        for (int k = 0; k < 64; k++)
            check(wlog[k] == 6'((61 + k) % 64), "R3 address step", wlog[k], (61 + k) % 64);
        for (int a = 0; a < 64; a++)
            check(mem[a] == pat(a), "R2 stored data", mem[a], pat(a));

        // R4 R5: read all 64 words from address 40
        sel_low();
        send_bits(16'b110, 3);
        send_bits(16'd40, 6);
        check(host_doe == 1'b0, "R5 doe before read strobe", host_doe, 0);
        for (int k = 0; k < 64; k++) begin
            rd_nib(d, oe);
            check(d == pat((40 + k) % 64), "R4 read data", d, pat((40 + k) % 64));
            check(oe == 1'b1, "R5 doe in read phase", oe, 1);
        end
        sel_high();
        check(host_doe == 1'b0, "R5 doe after select high", host_doe, 0);

        // R6 R7: twenty commands after a single code
        sel_low();
        send_bits(16'b100, 3);
        for (int i = 0; i < 20; i++) send_bits(16'((i * 37 + 11) % 512), 9);
        sel_high();
        check(cmd_n == 20, "R7 command count", cmd_n, 20);
        for (int i = 0; i < 20; i++)
            check(clog[i] == 9'((i * 37 + 11) % 512), "R6 command code", clog[i], (i * 37 + 11) % 512);

        // R8: partial write aborted by select high, then new window
        w0 = wcount; c0 = cmd_n;
        sel_low();
        send_bits(16'b101, 3);
        send_bits(16'd7, 6);
        send_bits(16'b00, 2);
        sel_high();
        sel_low();
        send_bits(16'b1111, 4);
        sel_high();
        check(wcount == w0, "R8 aborted write", wcount, w0);
        check(mem[7] == pat(7), "R8 word untouched", mem[7], pat(7));
        // R8: command mode does not survive select high
        sel_low();
        send_bits(16'h0AB, 9);
        sel_high();
        check(cmd_n == c0, "R8 mode cleared", cmd_n, c0);

        // R9: unknown code 111 drops a following address and data
        sel_low();
        send_bits(16'b111, 3);
        send_bits(16'd9, 6);
        send_nib(4'h0);
        send_bits(16'b100, 3);
        send_bits(16'h155, 9);
        sel_high();
        check(wcount == w0, "R9 no write", wcount, w0);
        check(cmd_n == c0, "R9 no command", cmd_n, c0);
        check(mem[9] == pat(9), "R9 word untouched", mem[9], pat(9));

        // R3 R4: wrap at 63 for a short write and read-back
        sel_low();
        send_bits(16'b101, 3);
        send_bits(16'd63, 6);
        send_nib(4'hA);
        send_nib(4'h5);
        sel_high();
        check(mem[63] == 4'hA, "R3 word at 63", mem[63], 10);
        check(mem[0] == 4'h5, "R3 wrap to 0", mem[0], 5);
        sel_low();
        send_bits(16'b110, 3);
        send_bits(16'd63, 6);
        rd_nib(d, oe);
        check(d == 4'hA, "R4 read at 63", d, 10);
        rd_nib(d, oe);
        check(d == 4'h5, "R4 read wrap", d, 5);
        sel_high();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule